// File: doc/BRIEF.md
# Prescaled 16-bit Counter with Coherent Byte Reads

This block is a free-running 16-bit up-counter that a processor with an 8-bit register bus reads and writes one byte at a time. A 2-bit source field picks the count pulses. There are two fixed divisions of the system clock, a pulse input from a neighbouring timer's overflow, and falling edges on an external pin. The pin is synchronized before its edges are detected.

A read of the low byte copies the high byte into a holding register in the same cycle, and a later high-byte read returns that copy. Software reads the low byte first and the high byte second, and gets a 16-bit value that belongs to one instant even while the counter keeps running. When the count wraps to zero, a sticky flag is set. The flag drives an interrupt request only while its enable bit is set. A control bit can freeze the count whenever the core reports that it is idle.

Top module: `snapcnt_top`

## Requirements
- R1: After reset the count is 0x0000, the holding register is 0x00, the control register reads 0x00, the status register reads 0x00 and `irq` is low.
- R2: Register map by `bus_addr`: 0 is the count low byte, 1 is the high byte (reads return the holding register), 2 is control (bit 0 interrupt enable, bits 2:1 source select, bit 7 idle freeze, other bits read 0), and 3 is status (bit 0 overflow flag). A write to address 0 or 1 loads that byte of the count on the next edge, leaves the other byte unchanged, and suppresses the increment in that cycle.
- R3: A read of address 0 captures the current high byte into the holding register at that clock edge. A later read of address 1 returns the captured value, even if the count has since carried into the high byte.
- R4: Reads never stall or change the count. Without a write, the count changes by at most one per cycle.
- R5: Source select 00 advances the count once every 12 system clocks.
- R6: Source select 01 advances the count once every 4 system clocks.
- R7: Source select 10 advances the count once for each cycle in which `tmr_ovf_in` is high.
- R8: Source select 11 advances the count once for each high-to-low transition of `ext_cnt_in`, after a two-flop synchronizer. Each input level must be held for at least two clocks, which limits the rate to one count per 4 clocks.
- R9: A step from 0xFFFF wraps the count to 0x0000 and sets the overflow flag.
- R10: `irq` is high exactly when the overflow flag is 1 and the interrupt enable bit is 1.
- R11: The overflow flag is cleared only by a write to status with bit 0 equal to 0. A write with bit 0 equal to 1 has no effect. A wrap in the same cycle as a clear leaves the flag set.
- R12: With idle freeze at 1 and `core_idle` high, the count holds. With idle freeze at 0, the count keeps running while `core_idle` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register, combinational |
| tmr_ovf_in | input | 1 | Overflow pulses from a neighbouring timer |
| ext_cnt_in | input | 1 | Asynchronous external count input |
| core_idle | input | 1 | High while the processor core is idle |
| irq | output | 1 | Overflow interrupt request |

## Verification
On every cycle the assertions check that the count moves by at most one step when there is no write, and that a byte write lands in the count. They also check that the holding register follows a low-byte read, that a wrap from all ones sets the flag, that the flag stays set until a clearing write, that the count freezes under idle, and that `irq` is gated by the enable bit. Only the bench scenarios show the absolute pulse rates of the four sources: the exact count over 48 and 40 clock windows, one step per timer pulse, and one step per pin falling edge after synchronization. The same holds for the full software sequence of a coherent low-then-high read across a carry, and for the visible register map.

// File: rtl/snapcnt_pkg.sv
// Package: shared encodings for the snapshot counter.
// Assumes a 2-bit register address and a 2-bit source select field.
package snapcnt_pkg;

    typedef enum logic [1:0] {
        SRC_DIV_SLOW = 2'b00,
        SRC_DIV_FAST = 2'b01,
        SRC_TMR_OVF  = 2'b10,
        SRC_EXT_FALL = 2'b11
    } src_sel_e;

    typedef enum logic [1:0] {
        ADDR_CNT_LO = 2'b00,
        ADDR_CNT_HI = 2'b01,
        ADDR_CTRL   = 2'b10,
        ADDR_STAT   = 2'b11
    } reg_addr_e;

    localparam int CTRL_IRQ_EN_BIT  = 0;
    localparam int CTRL_SRC_LSB     = 1;
    localparam int CTRL_IDLE_FRZ_BIT = 7;
    localparam int STAT_FLAG_BIT    = 0;

endpackage

// File: rtl/snapcnt_divider.sv
// Free-running clock-enable divider. It emits a single-cycle pulse once
// every DIV clocks, whatever source is selected downstream.
// Assumes DIV >= 2.
module snapcnt_divider #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic pulse
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;

    // Wrap the phase counter at DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (phase_q == LAST)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    assign pulse = (phase_q == LAST);
endmodule

// File: rtl/snapcnt_edge.sv
// Synchronizes an asynchronous input through SYNC_STAGES flops and
// produces a one-cycle pulse on each high-to-low transition.
// Assumes each input level is held for at least two clocks.
module snapcnt_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic fall_pulse
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                // First stage samples the raw pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= async_in;
                end
            end else begin : g_next
                // Later stages settle the previous stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    assign fall_pulse = last_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/snapcnt_core.sv
// Counter core: the 16-bit count, byte loads, the high-byte holding
// register and the sticky overflow flag.
// Assumes at most one of lo_wr / hi_wr is high in a cycle.
module snapcnt_core #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cnt_step,
    input  logic                lo_wr,
    input  logic                hi_wr,
    input  logic                lo_rd,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic                flag_clr,
    output logic [2*BYTE_W-1:0] cnt_q,
    output logic [BYTE_W-1:0]   snap_q,
    output logic                flag_q
);
    localparam int CNT_W = 2 * BYTE_W;

    logic wrap;

    assign wrap = cnt_step && !lo_wr && !hi_wr && (cnt_q == {CNT_W{1'b1}});

    // Count register: byte writes win over the increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (lo_wr)
            cnt_q[BYTE_W-1:0] <= wdata;
        else if (hi_wr)
            cnt_q[CNT_W-1:BYTE_W] <= wdata;
        else if (cnt_step)
            cnt_q <= cnt_q + 1'b1;
    end

    // Holding register: captures the high byte on a low-byte read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            snap_q <= '0;
        else if (lo_rd)
            snap_q <= cnt_q[CNT_W-1:BYTE_W];
    end

    // Sticky overflow flag: a wrap outranks a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (wrap)
            flag_q <= 1'b1;
        else if (flag_clr)
            flag_q <= 1'b0;
    end
endmodule

// File: rtl/snapcnt_top.sv
// Top of the prescaled counter: control register, source mux, idle gating,
// read mux and interrupt output.
// Assumes one bus access per cycle and a synchronous tmr_ovf_in.
module snapcnt_top
    import snapcnt_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int DIV_SLOW    = 12,
    parameter int DIV_FAST    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              tmr_ovf_in,
    input  logic              ext_cnt_in,
    input  logic              core_idle,
    output logic              irq
);
    localparam int CNT_W = 2 * BYTE_W;

    reg_addr_e          addr;
    src_sel_e           src_q;
    logic               irq_en_q;
    logic               idle_frz_q;
    logic               slow_pulse, fast_pulse, ext_fall;
    logic               src_tick, cnt_step;
    logic               lo_wr, hi_wr, lo_rd, flag_clr;
    logic [CNT_W-1:0]   cnt_q;
    logic [BYTE_W-1:0]  snap_q;
    logic               flag_q;

    assign addr = reg_addr_e'(bus_addr);

    snapcnt_divider #(.DIV(DIV_SLOW)) u_div_slow (
        .clk(clk), .rst_n(rst_n), .pulse(slow_pulse)
    );

    snapcnt_divider #(.DIV(DIV_FAST)) u_div_fast (
        .clk(clk), .rst_n(rst_n), .pulse(fast_pulse)
    );

    snapcnt_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .async_in(ext_cnt_in), .fall_pulse(ext_fall)
    );

    // Control register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en_q   <= 1'b0;
            src_q      <= SRC_DIV_SLOW;
            idle_frz_q <= 1'b0;
        end else if (bus_wr && addr == ADDR_CTRL) begin
            irq_en_q   <= bus_wdata[CTRL_IRQ_EN_BIT];
            src_q      <= src_sel_e'(bus_wdata[CTRL_SRC_LSB +: 2]);
            idle_frz_q <= bus_wdata[CTRL_IDLE_FRZ_BIT];
        end
    end

    // Select the count pulse source.
    always_comb begin
        unique case (src_q)
            SRC_DIV_SLOW: src_tick = slow_pulse;
            SRC_DIV_FAST: src_tick = fast_pulse;
            SRC_TMR_OVF:  src_tick = tmr_ovf_in;
            SRC_EXT_FALL: src_tick = ext_fall;
            default:      src_tick = 1'b0;
        endcase
    end

    assign cnt_step = src_tick && !(idle_frz_q && core_idle);
    assign lo_wr    = bus_wr && addr == ADDR_CNT_LO;
    assign hi_wr    = bus_wr && addr == ADDR_CNT_HI;
    assign lo_rd    = bus_rd && addr == ADDR_CNT_LO;
    assign flag_clr = bus_wr && addr == ADDR_STAT && !bus_wdata[STAT_FLAG_BIT];

    snapcnt_core #(.BYTE_W(BYTE_W)) u_core (
        .clk(clk), .rst_n(rst_n), .cnt_step(cnt_step),
        .lo_wr(lo_wr), .hi_wr(hi_wr), .lo_rd(lo_rd),
        .wdata(bus_wdata), .flag_clr(flag_clr),
        .cnt_q(cnt_q), .snap_q(snap_q), .flag_q(flag_q)
    );

    // Read data mux for the selected register.
    always_comb begin
        bus_rdata = '0;
        unique case (addr)
            ADDR_CNT_LO: bus_rdata = cnt_q[BYTE_W-1:0];
            ADDR_CNT_HI: bus_rdata = snap_q;
            ADDR_CTRL: begin
                bus_rdata[CTRL_IRQ_EN_BIT]     = irq_en_q;
                bus_rdata[CTRL_SRC_LSB +: 2]   = src_q;
                bus_rdata[CTRL_IDLE_FRZ_BIT]   = idle_frz_q;
            end
            ADDR_STAT:   bus_rdata[STAT_FLAG_BIT] = flag_q;
            default:     bus_rdata = '0;
        endcase
    end

    assign irq = flag_q && irq_en_q;
endmodule

// File: rtl/snapcnt_chk.sv
// Checker bound to snapcnt_top: temporal properties on count, holding
// register, flag and interrupt. Assumes BYTE_W matches the top.
module snapcnt_chk #(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          bus_addr,
    input logic                bus_rd,
    input logic                bus_wr,
    input logic [BYTE_W-1:0]   bus_wdata,
    input logic [2*BYTE_W-1:0] cnt_q,
    input logic [BYTE_W-1:0]   snap_q,
    input logic                flag_q,
    input logic                irq,
    input logic                irq_en_q,
    input logic                idle_frz_q,
    input logic                core_idle,
    input logic                cnt_step
);
    localparam int CNT_W = 2 * BYTE_W;

    p_load_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> cnt_q[BYTE_W-1:0] == $past(bus_wdata));

    p_snap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd0) |=> snap_q == $past(cnt_q[CNT_W-1:BYTE_W]));

    p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));

    p_wrap_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && cnt_step && cnt_q == {CNT_W{1'b1}}) |=> (flag_q && cnt_q == '0));

    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_q |-> !irq);

    p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag_q);

    p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(bus_wr && bus_addr == 2'd3 && !bus_wdata[0])) |=> flag_q);

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_frz_q && core_idle && !bus_wr) |=> $stable(cnt_q));
endmodule

bind snapcnt_top snapcnt_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .cnt_q(cnt_q), .snap_q(snap_q),
    .flag_q(flag_q), .irq(irq), .irq_en_q(irq_en_q), .idle_frz_q(idle_frz_q),
    .core_idle(core_idle), .cnt_step(cnt_step)
);

// File: tb/snapcnt_top_test.sv
`timescale 1ns/1ps
// Directed bench for snapcnt_top: one task per scenario.
module snapcnt_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tmr_ovf_in = 1'b0;
    logic       ext_cnt_in = 1'b0;
    logic       core_idle = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    snapcnt_top uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr_ovf_in(tmr_ovf_in), .ext_cnt_in(ext_cnt_in),
        .core_idle(core_idle), .irq(irq)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1 bus_rd = 1'b0;
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1 bus_wr = 1'b0;
    endtask

    task automatic tmr_pulse();
        @(negedge clk); tmr_ovf_in = 1'b1;
        @(negedge clk); tmr_ovf_in = 1'b0;
    endtask

    // Count increments of the low byte over exactly n clocks.
    task automatic span(input int n, output logic [7:0] diff);
        logic [7:0] a, b;
        reg_rd(2'd0, a);
        repeat (n - 1) @(negedge clk);
        reg_rd(2'd0, b);
        diff = b - a;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        reg_rd(2'd0, d); chk(d, 8'h00, "R1 low byte");
        reg_rd(2'd1, d); chk(d, 8'h00, "R1 high byte");
        reg_rd(2'd2, d); chk(d, 8'h00, "R1 control");
        reg_rd(2'd3, d); chk(d, 8'h00, "R1 status");
        chk({7'd0, irq}, 8'h00, "R1 irq");
    endtask

    task automatic t_rates();
        logic [7:0] d;
        reg_wr(2'd2, 8'h00);
        span(48, d); chk(d, 8'd4, "R5 div12 over 48 clocks");
        reg_wr(2'd2, 8'h02);
        reg_rd(2'd2, d); chk(d, 8'h02, "R2 control readback");
        span(40, d); chk(d, 8'd10, "R6 div4 over 40 clocks");
    endtask

    task automatic t_read_no_disturb();
        logic [7:0] first, last;
        reg_rd(2'd0, first);
        for (int i = 0; i < 40; i++) reg_rd(2'd0, last);
        chk(last - first, 8'd10, "R4 back-to-back reads keep rate");
    endtask

    task automatic t_tmr_src();
        logic [7:0] a, b;
        reg_wr(2'd2, 8'h04);
        reg_rd(2'd0, a);
        for (int i = 0; i < 5; i++) begin
            tmr_pulse();
            repeat (3) @(negedge clk);
        end
        reg_rd(2'd0, b);
        chk(b - a, 8'd5, "R7 five timer pulses");
    endtask

    task automatic t_ext_src();
        logic [7:0] a, b;
        reg_wr(2'd2, 8'h06);
        repeat (6) @(negedge clk);
        reg_rd(2'd0, a);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk) ext_cnt_in = 1'b1;
            repeat (4) @(negedge clk);
            ext_cnt_in = 1'b0;
            repeat (4) @(negedge clk);
        end
        repeat (8) @(negedge clk);
        reg_rd(2'd0, b);
        chk(b - a, 8'd6, "R8 six falling edges");
    endtask

    task automatic t_loads_and_snap();
        logic [7:0] d;
        reg_wr(2'd2, 8'h04);
        reg_wr(2'd1, 8'h12);
        reg_wr(2'd0, 8'hFF);
        reg_rd(2'd0, d); chk(d, 8'hFF, "R2 low byte load");
        tmr_pulse();
        reg_rd(2'd1, d); chk(d, 8'h12, "R3 high read returns captured byte");
        reg_rd(2'd0, d); chk(d, 8'h00, "R3 low byte after carry");
        reg_rd(2'd1, d); chk(d, 8'h13, "R2 R3 high byte after new capture");
    endtask

    task automatic t_overflow();
        logic [7:0] d;
        reg_wr(2'd2, 8'h04);
        reg_wr(2'd1, 8'hFF);
        reg_wr(2'd0, 8'hFF);
        reg_rd(2'd3, d); chk(d, 8'h00, "R9 flag clear before wrap");
        tmr_pulse();
        reg_rd(2'd3, d); chk(d, 8'h01, "R9 flag set on wrap");
        reg_rd(2'd0, d); chk(d, 8'h00, "R9 count wrapped to zero");
        chk({7'd0, irq}, 8'h00, "R10 irq low while disabled");
        reg_wr(2'd2, 8'h05);
        @(negedge clk); chk({7'd0, irq}, 8'h01, "R10 irq high when enabled");
        reg_wr(2'd3, 8'h01);
        reg_rd(2'd3, d); chk(d, 8'h01, "R11 write of one keeps flag");
        repeat (5) @(negedge clk);
        reg_rd(2'd3, d); chk(d, 8'h01, "R11 flag stays without clear");
        reg_wr(2'd3, 8'h00);
        reg_rd(2'd3, d); chk(d, 8'h00, "R11 write of zero clears flag");
        chk({7'd0, irq}, 8'h00, "R10 irq drops with flag");
    endtask

    task automatic t_idle();
        logic [7:0] d;
        reg_wr(2'd2, 8'h82);
        core_idle = 1'b1;
        span(40, d); chk(d, 8'd0, "R12 frozen while idle");
        core_idle = 1'b0;
        span(40, d); chk(d, 8'd10, "R12 runs when not idle");
        reg_wr(2'd2, 8'h02);
        core_idle = 1'b1;
        span(40, d); chk(d, 8'd10, "R12 runs in idle with freeze off");
        core_idle = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rates();
        t_read_no_disturb();
        t_tmr_src();
        t_ext_src();
        t_loads_and_snap();
        t_overflow();
        t_idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule